// File: doc/BRIEF.md
# Background Flash Streaming Read Engine

This engine copies a linear run of 32-bit words out of flash into a two-word FIFO, in the background, so that a DMA can collect them later. Software first loads a word-aligned start address and then a nonzero word count. The engine issues single-word read requests to the flash port. It only does so on cycles when that port reports no other traffic. Each returned word is pushed into the FIFO, and reading the FIFO data port pops one word.

The flash port returns read data in order, one word per response pulse, after any latency. Writing zero to the count stops the stream. Responses to reads that were issued before the stop are discarded and never reach the FIFO, so a new stream can be started at once. The FIFO level is visible through a full flag and an empty flag.

Top module: `flash_stream_engine`

## Requirements
- R1: The stream address keeps bits 31:2 only. Bits 1:0 of a written value are ignored, so `stream_addr` and `fl_addr` always have bits 1:0 equal to 0.
- R2: Each issued request advances the stream address by 4. A write to the address while a stream is active is used by the next request issued. If a request and an address write fall in the same cycle, the request uses the old address and the written value wins.
- R3: The count is 22 bits wide. A nonzero write starts a stream. The count drops by exactly 1 per issued request, and no request is issued while the count is 0. A stream of N therefore issues exactly N requests, and a cycle that writes the count issues no request.
- R4: Writing 0 to the count halts the stream. Every response to a read issued before that write is discarded, including one that arrives in the same cycle. A new stream may be started on the next cycle, and only its data reaches the FIFO.
- R5: `fl_req` is never high while `fl_busy` is high.
- R6: The FIFO holds 2 words in order. `stat` bit 2 is 1 exactly when 2 words are held, bit 1 is 1 exactly when none is held, and bit 0 is always 0. After reset `stat` is 3'b010.
- R7: A request is issued whenever the count is nonzero, the port is idle, the count is not being written, and the words held plus live reads in flight number fewer than 2. No request is issued otherwise.
- R8: A pop with the FIFO empty returns 0 on `pop_data` and leaves the FIFO unchanged.
- R9: While the FIFO is not empty, `pop_data` shows the oldest word. A pop removes that word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_sel | input | 1 | Write target: 0 = address, 1 = count |
| cfg_wr_data | input | 32 | Register write value |
| stream_addr | output | 32 | Next address to be requested |
| stream_count | output | 22 | Requests still to issue |
| pop_req | input | 1 | Pop one FIFO word this cycle |
| pop_data | output | 32 | Oldest FIFO word, or 0 when empty |
| stat | output | 3 | {full, empty, 0} |
| fl_busy | input | 1 | Flash port carries other traffic this cycle |
| fl_req | output | 1 | Single-word read request |
| fl_addr | output | 32 | Request address |
| fl_rvalid | input | 1 | Read response valid |
| fl_rdata | input | 32 | Read response data |

## Verification
A wrong in-flight or drop count shows up on `fl_req` within one cycle. The bench predicts exactly when a request must appear from its own FIFO and flight bookkeeping, so a missing or extra request fails at once. A drop count that misses a response pushes stale data, and that stale word appears as a wrong `pop_data` at the next pop. Errors in the address or count register show up in the same cycle on `stream_addr`, `stream_count` and `fl_addr`.

// File: rtl/flash_stream_engine.sv
module flash_stream_engine #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int CW = 22,
  parameter int OW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr_en,
  input  logic          cfg_wr_sel,
  input  logic [AW-1:0] cfg_wr_data,
  output logic [AW-1:0] stream_addr,
  output logic [CW-1:0] stream_count,
  input  logic          pop_req,
  output logic [DW-1:0] pop_data,
  output logic [2:0]    stat,
  input  logic          fl_busy,
  output logic          fl_req,
  output logic [AW-1:0] fl_addr,
  input  logic          fl_rvalid,
  input  logic [DW-1:0] fl_rdata
);
  logic [AW-1:2] addr_q;
  logic [CW-1:0] cnt_q;
  logic [OW-1:0] out_q, drop_q, live;
  logic [DW-1:0] mem [2];
  logic          wp, rp;
  logic [1:0]    lvl;

  wire wr_addr = cfg_wr_en & ~cfg_wr_sel;
  wire wr_cnt  = cfg_wr_en & cfg_wr_sel;
  wire abort   = wr_cnt & (cfg_wr_data[CW-1:0] == '0);
  wire rsp_drop = fl_rvalid & (abort | (drop_q != '0));
  wire push    = fl_rvalid & ~rsp_drop;
  wire pop     = pop_req & (lvl != 2'd0);

  assign live = out_q - drop_q;
  assign fl_req = (cnt_q != '0) & ~fl_busy & ~wr_cnt &
                  ((OW'(lvl) + live) < OW'(2)) & (out_q != '1);
  assign stream_addr  = {addr_q, 2'b00};
  assign fl_addr      = stream_addr;
  assign stream_count = cnt_q;
  assign pop_data     = (lvl == 2'd0) ? '0 : mem[rp];
  assign stat         = {lvl == 2'd2, lvl == 2'd0, 1'b0};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      cnt_q  <= '0;
      out_q  <= '0;
      drop_q <= '0;
    end else begin
      if (wr_addr)     addr_q <= cfg_wr_data[AW-1:2];
      else if (fl_req) addr_q <= addr_q + 1'b1;
      if (wr_cnt)      cnt_q <= cfg_wr_data[CW-1:0];
      else if (fl_req) cnt_q <= cnt_q - 1'b1;
      out_q <= out_q + OW'(fl_req) - OW'(fl_rvalid);
      if (abort)                  drop_q <= out_q - OW'(fl_rvalid);
      else if (rsp_drop)          drop_q <= drop_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem[0] <= '0;
      mem[1] <= '0;
      wp     <= 1'b0;
      rp     <= 1'b0;
      lvl    <= 2'd0;
    end else begin
      if (push) begin
        mem[wp] <= fl_rdata;
        wp      <= ~wp;
      end
      if (pop) rp <= ~rp;
      lvl <= lvl + 2'(push) - 2'(pop);
    end
  end
endmodule

// File: rtl/flash_stream_engine_chk.sv
module flash_stream_engine_chk #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int CW = 22
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_wr_en,
  input logic [AW-1:0] stream_addr,
  input logic [CW-1:0] stream_count,
  input logic          pop_req,
  input logic [DW-1:0] pop_data,
  input logic [2:0]    stat,
  input logic          fl_busy,
  input logic          fl_req,
  input logic [AW-1:0] fl_addr,
  input logic          fl_rvalid
);
  AST_ADDR_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    stream_addr[1:0] == 2'b00 && fl_addr[1:0] == 2'b00); // R1
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    fl_req && !cfg_wr_en |=> stream_addr == $past(fl_addr) + AW'(4)); // R2
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    fl_req && !cfg_wr_en |=> stream_count == $past(stream_count) - 1'b1); // R3
  AST_NO_REQ_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    stream_count == '0 |-> !fl_req); // R3
  AST_IDLE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    fl_req |-> !fl_busy); // R5
  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(stat[2] && stat[1]) && !stat[0]); // R6
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    stat[2] |-> !fl_req); // R7
  AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
    stat[1] && pop_req && !fl_rvalid |=> stat[1]); // R8
  AST_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    stat[1] |-> pop_data == '0); // R8
endmodule

bind flash_stream_engine flash_stream_engine_chk #(.AW(AW), .DW(DW), .CW(CW)) chk_i (
  .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .stream_addr(stream_addr),
  .stream_count(stream_count), .pop_req(pop_req), .pop_data(pop_data), .stat(stat),
  .fl_busy(fl_busy), .fl_req(fl_req), .fl_addr(fl_addr), .fl_rvalid(fl_rvalid)
);

// File: tb/flash_stream_engine_test.sv
module flash_stream_engine_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr_en = 1'b0, cfg_wr_sel = 1'b0;
  logic [31:0] cfg_wr_data = '0;
  logic [31:0] stream_addr;
  logic [21:0] stream_count;
  logic        pop_req = 1'b0;
  logic [31:0] pop_data;
  logic [2:0]  stat;
  logic        fl_busy = 1'b0, fl_req;
  logic [31:0] fl_addr;
  logic        fl_rvalid = 1'b0;
  logic [31:0] fl_rdata = '0;

  always #10 clk = ~clk;

  flash_stream_engine uut (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_sel(cfg_wr_sel),
    .cfg_wr_data(cfg_wr_data), .stream_addr(stream_addr), .stream_count(stream_count),
    .pop_req(pop_req), .pop_data(pop_data), .stat(stat), .fl_busy(fl_busy),
    .fl_req(fl_req), .fl_addr(fl_addr), .fl_rvalid(fl_rvalid), .fl_rdata(fl_rdata));

  int total = 0, bad = 0, cyc = 0, lat = 2, nreq = 0;
  bit done = 0;
  logic [31:0] expq[$];
  int          pend_due[$];
  logic [31:0] pend_addr[$];
  bit          pend_live[$];
  logic [31:0] exp_addr = '0;
  logic [21:0] exp_cnt = '0;

  function automatic logic [31:0] fword(input logic [31:0] a);
    return {a[15:0], ~a[15:0]} ^ 32'h5A3C_96E1;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic step(input logic b, input logic we, input logic ws,
                      input logic [31:0] wd, input logic pp);
    int  nlive;
    bit  exp_req;
    bit  rv;
    fl_busy = b; cfg_wr_en = we; cfg_wr_sel = ws; cfg_wr_data = wd; pop_req = pp;
    rv = (pend_due.size() > 0) && (pend_due[0] == cyc);
    fl_rvalid = rv;
    fl_rdata  = rv ? fword(pend_addr[0]) : 32'h0;
    #1;
    nlive = 0;
    foreach (pend_live[i]) if (pend_live[i]) nlive++;
    chk(stat == {expq.size() == 2, expq.size() == 0, 1'b0}, "R6 stat", {29'd0, stat},
        {29'd0, expq.size() == 2, expq.size() == 0, 1'b0});
    chk(stream_count == exp_cnt, "R3 count", {10'd0, stream_count}, {10'd0, exp_cnt});
    chk(stream_addr == exp_addr, "R1/R2 addr", stream_addr, exp_addr);
    exp_req = (exp_cnt != 0) && !b && !(we && ws) && (expq.size() + nlive < 2);
    chk(fl_req == exp_req, "R7 request", {31'd0, fl_req}, {31'd0, exp_req});
    if (fl_req) begin
      chk(!b, "R5 idle only", {31'd0, b}, 32'd0);
      chk(fl_addr == exp_addr, "R2 fl_addr", fl_addr, exp_addr);
    end
    if (pp) begin
      if (expq.size() == 0) chk(pop_data == 0, "R8 empty pop", pop_data, 32'd0);
      else chk(pop_data == expq[0], "R9 pop data", pop_data, expq[0]);
    end
    if (pp && expq.size() > 0) void'(expq.pop_front());
    if (we && ws && wd[21:0] == 0) foreach (pend_live[i]) pend_live[i] = 1'b0;
    if (rv) begin
      if (pend_live[0]) expq.push_back(fl_rdata);
      void'(pend_due.pop_front()); void'(pend_addr.pop_front()); void'(pend_live.pop_front());
    end
    if (fl_req) begin
      pend_due.push_back(cyc + lat); pend_addr.push_back(fl_addr); pend_live.push_back(1'b1);
      exp_addr = exp_addr + 4; exp_cnt = exp_cnt - 1; nreq++;
    end
    if (we && !ws) exp_addr = {wd[31:2], 2'b00};
    if (we && ws)  exp_cnt = wd[21:0];
    @(negedge clk);
    cyc++;
  endtask

  task automatic idle(input int n, input logic pp);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 1'b0, 32'h0, pp);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      chk(1'b0, "watchdog", 32'd0, 32'd1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state: R6, R8
    chk(stat == 3'b010, "R6 reset stat", {29'd0, stat}, 32'd2);
    chk(!fl_req, "R3 reset idle", {31'd0, fl_req}, 32'd0);
    idle(2, 1'b1);

    // R1: low address bits dropped
    step(1'b0, 1'b1, 1'b0, 32'h0000_1003, 1'b0);
    chk(stream_addr == 32'h1000, "R1 align", stream_addr, 32'h1000);

    // random stream: R2 R3 R5 R7 R9
    lat = 2; nreq = 0;
    step(1'b0, 1'b1, 1'b1, 32'd12, 1'b0);
    for (int i = 0; i < 90; i++)
      step(($urandom % 10) < 3, 1'b0, 1'b0, 32'h0, ($urandom % 10) < 4);
    idle(8, 1'b1);
    chk(nreq == 12, "R3 request total", nreq, 32'd12);
    chk(stream_addr == 32'h1030, "R2 final addr", stream_addr, 32'h1030);

    // credit without pops: R7
    lat = 3; nreq = 0;
    step(1'b0, 1'b1, 1'b1, 32'd6, 1'b0);
    idle(15, 1'b0);
    chk(nreq == 2, "R7 credit limit", nreq, 32'd2);
    chk(stat == 3'b100, "R6 full", {29'd0, stat}, 32'd4);
    idle(1, 1'b1);
    idle(6, 1'b0);
    chk(nreq == 3, "R7 credit after pop", nreq, 32'd3);
    step(1'b0, 1'b1, 1'b1, 32'd0, 1'b0);
    idle(10, 1'b1);

    // abort with reads in flight: R4
    lat = 3; nreq = 0;
    step(1'b0, 1'b1, 1'b0, 32'h2000, 1'b0);
    step(1'b0, 1'b1, 1'b1, 32'd3, 1'b0);
    idle(2, 1'b0);
    chk(nreq == 2, "R4 two in flight", nreq, 32'd2);
    step(1'b0, 1'b1, 1'b1, 32'd0, 1'b0);
    step(1'b0, 1'b1, 1'b0, 32'h3000, 1'b0);
    step(1'b0, 1'b1, 1'b1, 32'd1, 1'b0);
    idle(10, 1'b0);
    chk(expq.size() == 1, "R4 only new data", expq.size(), 32'd1);
    chk(pop_data == fword(32'h3000), "R4 new word", pop_data, fword(32'h3000));
    idle(2, 1'b1);

    // abort in the same cycle as a response: R4
    lat = 1; nreq = 0;
    step(1'b0, 1'b1, 1'b0, 32'h4000, 1'b0);
    step(1'b0, 1'b1, 1'b1, 32'd4, 1'b0);
    step(1'b0, 1'b0, 1'b0, 32'h0, 1'b0);
    step(1'b0, 1'b1, 1'b1, 32'd0, 1'b0);
    idle(4, 1'b0);
    chk(stat == 3'b010, "R4 same-cycle drop", {29'd0, stat}, 32'd2);

    // address rewrite mid-stream: R2
    lat = 4; nreq = 0;
    step(1'b0, 1'b1, 1'b0, 32'h5000, 1'b0);
    step(1'b0, 1'b1, 1'b1, 32'd4, 1'b0);
    step(1'b0, 1'b1, 1'b0, 32'h6000, 1'b0);
    chk(stream_addr == 32'h6000, "R2 rewrite wins", stream_addr, 32'h6000);
    step(1'b0, 1'b0, 1'b0, 32'h0, 1'b0);
    chk(stream_addr == 32'h6004, "R2 next uses rewrite", stream_addr, 32'h6004);
    for (int i = 0; i < 30; i++) step(1'b0, 1'b0, 1'b0, 32'h0, 1'b1);
    chk(nreq == 4, "R3 four issued", nreq, 32'd4);

    // empty pops: R8
    idle(3, 1'b1);
    chk(stat == 3'b010 && pop_data == 0, "R8 empty unchanged", pop_data, 32'd0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule